// File: doc/BRIEF.md
# I2C Clock-Low Timeout Monitor

This block sits next to an I2C master's bit engine and watches for a slave that stretches the clock for too long. When the master sees a START, the block loads a 12-bit down-counter with a programmed 8-bit limit in the upper bits and zeros in the lower four. The counter steps down on every falling edge of the master's own internal bit clock. That clock keeps running at the configured bus rate even while SCL is held low, so the count measures the total time the transfer has taken. For example, a limit of 0xDA gives 3488 counts, which is 34.88 ms at 100 kHz.

When the count runs out, the block raises a raw interrupt flag and a sticky timeout status bit. It then waits until both SCL and SDA are seen high, and at that point sends the master state machine a single request to drive a STOP. The status bit clears when a STOP is sent or on reset. The interrupt flag clears through a write-one-to-clear pulse.

The controller has four states:
- IDLE: no transaction is running.
- COUNT: armed and counting down.
- WAIT_REL: timed out and waiting for both lines to be released.
- DONE: the abort has been issued.

The transitions are:
- IDLE→COUNT on a START with a legal limit.
- COUNT→WAIT_REL on the final falling-edge strobe.
- WAIT_REL→DONE when both lines are high.
- Any state→IDLE on a STOP.
- Any state→COUNT on a START with a legal limit, which reloads the counter.
- Any state→IDLE on a START with an illegal limit.

Top module: `i2c_lowclk_watchdog`

## Requirements
- R1: After reset, `irq_raw`, `clkto_stat` and `stop_req` are all 0.
- R2: A START with limit value V loads the counter with V·16 (V in bits 11:4, zeros in bits 3:0). The timeout happens on exactly the V·16-th falling-edge strobe, so 0xDA times out on strobe 3488 and not on strobe 3487.
- R3: The counter moves only on `bitclk_fall` strobes. Holding SCL or SDA low neither pauses nor speeds the count.
- R4: A START with limit 0x00 or 0x01 does not arm the timer. No timeout follows, however many strobes arrive.
- R5: `irq_raw` and `clkto_stat` both become 1 in the cycle after the clock edge that samples the final strobe.
- R6: After a timeout, `stop_req` is 1 for the cycle after the first edge at which `scl_in` and `sda_in` are both 1. It stays 0 while either line is low.
- R7: `stop_req` is a single-cycle pulse issued once per timeout. There is no further pulse until a new START reloads the counter.
- R8: `clkto_stat` clears on `stop_sent` or reset. `irq_clr` does not affect it.
- R9: `irq_raw` holds until an `irq_clr` pulse. An `irq_clr` in the same cycle as a new timeout leaves it set.
- R10: After a STOP and before the next START, the counter holds and no timeout or abort occurs.
- R11: A START in any state restarts timing from the new limit. START takes priority over a simultaneous STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bitclk_fall | input | 1 | One-cycle strobe per falling edge of the master's internal bit clock |
| start_det | input | 1 | START condition detected pulse |
| stop_sent | input | 1 | STOP condition sent pulse |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| limit_val | input | 8 | Programmed timeout, upper bits of the counter |
| irq_clr | input | 1 | Write-one-to-clear pulse for irq_raw |
| irq_raw | output | 1 | Raw clock-timeout interrupt flag |
| clkto_stat | output | 1 | Sticky clock-timeout status bit |
| stop_req | output | 1 | One-cycle request to drive an abort STOP |

## Verification
Two corner cases are hard to reach from the ports. The first is an `irq_clr` that lands in exactly the same cycle as the terminal strobe. The second is the off-by-one boundary of a long count. Directed sequences count strobes precisely: 3487 then 3488 for 0xDA, and 31 strobes followed by a strobe combined with a clear for the minimum legal limit. Seeded random traffic mixes STARTs with illegal limits, STOPs and line levels, and a bench model checks every output on every cycle.

// File: rtl/i2c_lowclk_pkg.sv
package i2c_lowclk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_COUNT    = 2'd1,
        ST_WAIT_REL = 2'd2,
        ST_DONE     = 2'd3
    } lowclk_state_e;
endpackage

// File: rtl/lowclk_counter.sv
module lowclk_counter #(
    parameter int VAL_W  = 8,
    parameter int FRAC_W = 4,
    localparam int CNT_W = VAL_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [VAL_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             last_step
);
    assign last_step = dec && (cnt == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= {load_val, {FRAC_W{1'b0}}};
        end else if (dec && cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assert_no_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && $past(cnt) == '0) |-> cnt == '0 || $past(load));
endmodule

// File: rtl/lowclk_flags.sv
module lowclk_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_to,
    input  logic irq_clr,
    input  logic stat_clr,
    output logic irq_raw,
    output logic clkto_stat
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_raw    <= 1'b0;
            clkto_stat <= 1'b0;
        end else begin
            if (set_to)       irq_raw <= 1'b1;
            else if (irq_clr) irq_raw <= 1'b0;
            if (set_to)        clkto_stat <= 1'b1;
            else if (stat_clr) clkto_stat <= 1'b0;
        end
    end

    assert_clear_collision_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_to && irq_clr) |=> irq_raw);
    assert_stat_only_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clkto_stat) |-> $past(stat_clr));
endmodule

// File: rtl/i2c_lowclk_watchdog.sv
module i2c_lowclk_watchdog
    import i2c_lowclk_pkg::*;
#(
    parameter int VAL_W  = 8,
    parameter int FRAC_W = 4,
    parameter int MIN_LEGAL = 2,
    localparam int CNT_W = VAL_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bitclk_fall,
    input  logic             start_det,
    input  logic             stop_sent,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic [VAL_W-1:0] limit_val,
    input  logic             irq_clr,
    output logic             irq_raw,
    output logic             clkto_stat,
    output logic             stop_req
);
    lowclk_state_e state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic legal, arm, dec, last_step, expire, released;

    assign legal    = (limit_val >= VAL_W'(MIN_LEGAL));
    assign arm      = start_det && legal;
    assign dec      = (state == ST_COUNT) && bitclk_fall && !start_det && !stop_sent;
    assign expire   = last_step;
    assign released = scl_in && sda_in;

    lowclk_counter #(.VAL_W(VAL_W), .FRAC_W(FRAC_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(arm), .load_val(limit_val),
        .dec(dec), .cnt(cnt), .last_step(last_step)
    );

    lowclk_flags u_flags (
        .clk(clk), .rst_n(rst_n), .set_to(expire), .irq_clr(irq_clr),
        .stat_clr(stop_sent && !start_det), .irq_raw(irq_raw), .clkto_stat(clkto_stat)
    );

    always_comb begin
        state_nx = state;
        if (start_det) begin
            state_nx = legal ? ST_COUNT : ST_IDLE;
        end else if (stop_sent) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_COUNT:    if (expire)   state_nx = ST_WAIT_REL;
                ST_WAIT_REL: if (released) state_nx = ST_DONE;
                ST_DONE:     state_nx = ST_DONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stop_req <= 1'b0;
        else        stop_req <= (state == ST_WAIT_REL) && released && !start_det && !stop_sent;
    end

    assert_req_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> !stop_req);
    assert_req_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |-> $past(scl_in && sda_in));
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start_det) |=> $stable(cnt));
    assert_flags_together_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clkto_stat) |-> irq_raw);
    assert_illegal_no_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !legal) |=> state == ST_IDLE);
endmodule

// File: tb/i2c_lowclk_watchdog_bench.sv
module i2c_lowclk_watchdog_bench;
    logic clk = 1'b0, rst_n = 1'b0;
    logic bitclk_fall = 0, start_det = 0, stop_sent = 0, scl_in = 1, sda_in = 1, irq_clr = 0;
    logic [7:0] limit_val = 8'h02;
    logic irq_raw, clkto_stat, stop_req;

    int n_tests = 0, n_fail = 0;
    int m_st = 0;
    int m_cnt = 0;
    bit m_irq = 0, m_stat = 0, m_req = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    i2c_lowclk_watchdog u_i2c_lowclk_watchdog (
        .clk(clk), .rst_n(rst_n), .bitclk_fall(bitclk_fall), .start_det(start_det),
        .stop_sent(stop_sent), .scl_in(scl_in), .sda_in(sda_in), .limit_val(limit_val),
        .irq_clr(irq_clr), .irq_raw(irq_raw), .clkto_stat(clkto_stat), .stop_req(stop_req)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_update();
        bit set = 0;
        m_req = 0;
        if (start_det) begin
            if (limit_val > 8'h01) begin m_st = 1; m_cnt = int'(limit_val) * 16; end
            else m_st = 0;
        end else if (stop_sent) begin
            m_st = 0;
            m_stat = 0;
        end else if (m_st == 1) begin
            if (bitclk_fall) begin
                m_cnt--;
                if (m_cnt == 0) begin m_st = 2; set = 1; end
            end
        end else if (m_st == 2) begin
            if (scl_in && sda_in) begin m_req = 1; m_st = 3; end
        end
        if (set) begin m_irq = 1; m_stat = 1; end
        else if (irq_clr) m_irq = 0;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        model_update();
        @(negedge clk);
        chk("R9 irq_raw", irq_raw, m_irq);
        chk("R8 clkto_stat", clkto_stat, m_stat);
        chk("R6 stop_req", stop_req, m_req);
    endtask

    task automatic quiet();
        bitclk_fall = 0; start_det = 0; stop_sent = 0; irq_clr = 0;
    endtask

    task automatic do_start(input logic [7:0] v);
        limit_val = v; start_det = 1; step(); quiet();
    endtask

    task automatic falls(input int n);
        for (int i = 0; i < n; i++) begin bitclk_fall = 1; step(); end
        bitclk_fall = 0;
    endtask

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        chk("R1 irq_raw reset", irq_raw, 1'b0);
        chk("R1 clkto_stat reset", clkto_stat, 1'b0);
        chk("R1 stop_req reset", stop_req, 1'b0);
        rst_n = 1;
        @(negedge clk);

        // R2, R3, R5: long count with both lines held low
        scl_in = 0; sda_in = 0;
        do_start(8'hDA);
        falls(3487);
        chk("R2 no timeout at 3487", irq_raw, 1'b0);
        falls(1);
        chk("R2 timeout at 3488", irq_raw, 1'b1);
        chk("R5 status set", clkto_stat, 1'b1);
        chk("R3 SCL low did not pause count", irq_raw, 1'b1);
        step(); step();
        chk("R6 no stop while lines low", stop_req, 1'b0);
        scl_in = 1; step();
        chk("R6 no stop with SDA low", stop_req, 1'b0);
        sda_in = 1; step();
        chk("R6 stop on release", stop_req, 1'b1);
        step();
        chk("R7 single pulse", stop_req, 1'b0);
        falls(40);
        chk("R7 no second abort", stop_req, 1'b0);
        irq_clr = 1; step(); quiet();
        chk("R9 irq cleared", irq_raw, 1'b0);
        chk("R8 irq_clr leaves status", clkto_stat, 1'b1);
        stop_sent = 1; step(); quiet();
        chk("R8 stop clears status", clkto_stat, 1'b0);

        // R4: illegal limits
        do_start(8'h01); falls(100);
        chk("R4 limit 0x01 not armed", irq_raw, 1'b0);
        do_start(8'h00); falls(100);
        chk("R4 limit 0x00 not armed", irq_raw, 1'b0);

        // R9: clear collides with terminal strobe
        do_start(8'h02); falls(31);
        bitclk_fall = 1; irq_clr = 1; step(); quiet();
        chk("R9 collision keeps flag", irq_raw, 1'b1);
        irq_clr = 1; step(); quiet();
        stop_sent = 1; step(); quiet();

        // R10: stop mid-count, then idle strobes
        do_start(8'h02); falls(10);
        stop_sent = 1; step(); quiet();
        falls(100);
        chk("R10 idle no timeout", irq_raw, 1'b0);
        chk("R10 idle no abort", stop_req, 1'b0);

        // R11: restart mid-count, and START beats STOP
        do_start(8'h02); falls(20);
        limit_val = 8'h03; start_det = 1; stop_sent = 1; step(); quiet();
        falls(47);
        chk("R11 reload no early timeout", irq_raw, 1'b0);
        falls(1);
        chk("R11 timeout after reload", irq_raw, 1'b1);
        irq_clr = 1; stop_sent = 1; step(); quiet();

        // random traffic checked against the model
        for (int c = 0; c < 20000; c++) begin
            start_det   = ($urandom % 40) == 0;
            stop_sent   = ($urandom % 60) == 0;
            bitclk_fall = ($urandom % 2) == 0;
            scl_in      = ($urandom % 3) != 0;
            sda_in      = ($urandom % 3) != 0;
            irq_clr     = ($urandom % 8) == 0;
            limit_val   = 8'($urandom % 5);
            step();
        end
        quiet();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule